// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches up to nine groups of sixteen general-purpose input lines and turns selected activity on them into one interrupt request. Each line is brought into the clock domain through a two-stage synchroniser. A per-block trigger code then decides what counts as an event: a level, a rising edge, a falling edge or either edge. An event on an unmasked line sets a sticky pending bit. Software clears pending bits by writing ones to them.

Registers pack two groups into each 32-bit word. The even group takes the low half and the odd group the high half, so group g sits in word g/2. A read-only service word gives one source to handle next, coded as a group number and a pin number. It reads zero when no unmasked line is pending, so an interrupt handler can loop on it until it returns zero. The bus is a simple select/write strobe interface with registered read data.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset all trigger words read 0, all pending words read 0, the service word reads 0, `irq` is low, and every implemented mask bit reads 1 (mask word at 0x240 reads 0xFFFF0000, the others 0xFFFFFFFF).
- R2: Trigger words are at 0x200 + 4*(g/2), mask words at 0x240 + 4*(g/2) and pending words at 0x260 + 4*(g/2). Line p of group g is bit 16*(g%2)+p. Written values read back, while bits 15:0 of each word at offset 0 (the nonexistent group 0) read 0 and ignore writes.
- R3: A 4-bit trigger code at bits 4*(i/4) of the trigger word covers the four lines with bit indices i..i with the same i/4. All four lines use that code.
- R4: Code 4 sets pending on a rising edge, code 2 on a falling edge, and code 6 on either edge. After an input change the pending bit, and `irq` if the line is unmasked, is set at the third rising clock edge.
- R5: Code 1 sets pending while the synchronised input is high, and code 0 while it is low. Pending comes back after a clear for as long as the level lasts. Codes other than 0, 1, 2, 4 and 6 never set pending.
- R6: A mask bit of 1 stops new events on that line from setting pending. It also removes a pending line from `irq` and from the service word. A bit that is already pending stays set and can be read.
- R7: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged. If an event occurs on the same edge as the clear, the pending bit stays set.
- R8: `irq` is high exactly when at least one pending bit is unmasked.
- R9: The service word at 0x284 returns the group in bits 7:4 and the pin in bits 3:0. It picks the lowest group, then the lowest pin, among pending unmasked lines, and reads 0 when there are none. Reading it changes nothing.
- R10: Read data and `bus_rvalid` appear one clock after a read select. Addresses that are not mapped read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | GROUPS*16 | Input lines; group g pin p is bit 16*(g-1)+p |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Combined interrupt request |

## Verification
An input change becomes a pending bit and an `irq` change at the third rising edge: two edges for the synchroniser and one for the pending register. The bench therefore checks `irq` low after two edges and high after the third. A register write takes effect at the edge of its strobe. `irq` follows a mask or clear write at once, while a level line newly unmasked pends one edge later; both are sampled at the falling edge that follows. Read results come back one clock after the select. A monitor takes them from the expected-value queue at the falling edge where `bus_rvalid` is high.

// File: rtl/gpio_group_irq.sv
module gpio_group_irq #(
  parameter int GROUPS = 9,
  parameter int ADDR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GROUPS*16-1:0]   gpio_in,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  output logic                   irq
);
  localparam int NPAIR = GROUPS / 2 + 1;
  localparam int FLAT  = NPAIR * 32;
  localparam int NLINE = GROUPS * 16;
  localparam int IDXW  = $clog2(FLAT);
  localparam logic [ADDR_W-1:0] TRIG_BASE = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] MASK_BASE = ADDR_W'(12'h240);
  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(12'h260);
  localparam logic [ADDR_W-1:0] SVC_ADDR  = ADDR_W'(12'h284);
  localparam logic [FLAT-1:0] ALL1 = '1;
  localparam logic [FLAT-1:0] IMPL = (ALL1 >> (FLAT - NLINE - 16)) & ~FLAT'(32'hFFFF);

  logic [FLAT-1:0] in_flat, s1, s2, prv, hit, newset, trig, mask, pend, clr, act;
  logic [31:0]     rd_word, svc_word;

  assign in_flat = FLAT'({gpio_in, 16'h0000});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prv <= '0;
    end else begin
      s1 <= in_flat; s2 <= s1; prv <= s2;
    end

  function automatic logic detect(input logic [3:0] code, input logic now, input logic was);
    case (code)
      4'd0:    return !now;
      4'd1:    return now;
      4'd2:    return was && !now;
      4'd4:    return !was && now;
      4'd6:    return was ^ now;
      default: return 1'b0;
    endcase
  endfunction

  for (genvar b = 0; b < FLAT; b++) begin : g_det
    assign hit[b] = detect(trig[4*(b/4) +: 4], s2[b], prv[b]);
  end

  assign newset = hit & ~mask & IMPL;
  assign act    = pend & ~mask;
  assign irq    = |act;

  for (genvar w = 0; w < NPAIR; w++) begin : g_clr
    assign clr[w*32 +: 32] = (bus_sel && bus_wr && bus_addr == PEND_BASE + ADDR_W'(4*w))
                             ? bus_wdata : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig <= '0;
      mask <= IMPL;
      pend <= '0;
    end else begin
      for (int w = 0; w < NPAIR; w++) begin
        if (bus_sel && bus_wr && bus_addr == TRIG_BASE + ADDR_W'(4*w))
          trig[w*32 +: 32] <= bus_wdata & IMPL[w*32 +: 32];
        if (bus_sel && bus_wr && bus_addr == MASK_BASE + ADDR_W'(4*w))
          mask[w*32 +: 32] <= bus_wdata & IMPL[w*32 +: 32];
      end
      pend <= (pend & ~clr) | newset;
    end

  always_comb begin
    logic [IDXW-1:0] idx;
    logic            found;
    idx = '0;
    found = 1'b0;
    for (int i = FLAT - 1; i >= 0; i--)
      if (act[i]) begin
        idx = IDXW'(i);
        found = 1'b1;
      end
    svc_word = found ? {24'h0, 4'(idx >> 4), idx[3:0]} : 32'h0;
  end

  always_comb begin
    rd_word = 32'h0;
    for (int w = 0; w < NPAIR; w++) begin
      if (bus_addr == TRIG_BASE + ADDR_W'(4*w)) rd_word = trig[w*32 +: 32];
      if (bus_addr == MASK_BASE + ADDR_W'(4*w)) rd_word = mask[w*32 +: 32];
      if (bus_addr == PEND_BASE + ADDR_W'(4*w)) rd_word = pend[w*32 +: 32];
    end
    if (bus_addr == SVC_ADDR) rd_word = svc_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_word;
    end

  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> svc_word[7:4] != 4'h0);
  assert_idle_service_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> svc_word == 32'h0);
  assert_masked_no_new_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & $past(mask)) == '0));
  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~newset)) |=> ((pend & $past(clr & ~newset)) == '0));
  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);
endmodule

// File: tb/gpio_group_irq_tb.sv
module gpio_group_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [143:0] gin = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  gpio_group_irq u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gin), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq));

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    cyc(1);
    bus_sel = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10: unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    check(32'(irq), 0, "R1 irq after reset");
    rd(12'h240, 32'hFFFF0000, "R1 mask word0");
    rd(12'h244, 32'hFFFFFFFF, "R1 mask word1");
    rd(12'h260, 32'h0, "R1 pend word0");
    rd(12'h200, 32'h0, "R1 trig word0");
    rd(12'h284, 32'h0, "R1 service idle");
    // R2 / R10 addressing
    wr(12'h204, 32'h12345678);
    rd(12'h204, 32'h12345678, "R2 trig readback");
    wr(12'h200, 32'hFFFFFFFF);
    rd(12'h200, 32'hFFFF0000, "R2 group0 half reads zero");
    wr(12'h300, 32'hDEADBEEF);
    rd(12'h300, 32'h0, "R10 unmapped read");
    rd(12'h204, 32'h12345678, "R10 unmapped write ignored");
    wr(12'h200, 0); wr(12'h204, 0);
    // R3 / R4 rising, group3 pins 5 and 6 share field 5
    wr(12'h204, 32'h00400000);
    wr(12'h244, 32'hFF9FFFFF);
    gin[37] = 1; gin[38] = 1;
    cyc(2); check(32'(irq), 0, "R4 irq not before third edge");
    cyc(1); check(32'(irq), 1, "R4 irq at third edge");
    rd(12'h264, 32'h00600000, "R3 shared rising field");
    rd(12'h284, 32'h35, "R9 service g3 p5");
    rd(12'h284, 32'h35, "R9 service read no side effect");
    wr(12'h264, 32'h00200000);
    rd(12'h264, 32'h00400000, "R7 w1c clears only ones");
    rd(12'h284, 32'h36, "R9 next source");
    wr(12'h264, 32'h00400000);
    check(32'(irq), 0, "R8 irq low after clear");
    gin[37] = 0; cyc(3);
    check(32'(irq), 0, "R4 rising code ignores fall");
    wr(12'h204, 32'h00600000);
    gin[37] = 1; cyc(3);
    check(32'(irq), 1, "R4 both-edge rise");
    wr(12'h264, 32'h00200000);
    gin[37] = 0; cyc(3);
    check(32'(irq), 1, "R4 both-edge fall");
    wr(12'h264, 32'h00200000);
    wr(12'h204, 32'h00200000);
    gin[37] = 1; cyc(3);
    check(32'(irq), 0, "R4 falling code ignores rise");
    gin[37] = 0; cyc(3);
    check(32'(irq), 1, "R4 falling code");
    wr(12'h264, 32'h00200000);
    wr(12'h244, 32'hFFFFFFFF); wr(12'h204, 0);
    // R5 level high, group9 pin15
    wr(12'h210, 32'h10000000);
    wr(12'h250, 32'h7FFFFFFF);
    gin[143] = 1; cyc(3);
    check(32'(irq), 1, "R5 level high");
    rd(12'h284, 32'h9F, "R9 service g9 p15");
    wr(12'h270, 32'h80000000);
    rd(12'h270, 32'h80000000, "R5 level re-pends after clear");
    gin[143] = 0; cyc(3);
    wr(12'h270, 32'h80000000);
    check(32'(irq), 0, "R5 level gone clear holds");
    wr(12'h250, 32'hFFFFFFFF);
    // R5 level low, group2 pin0 (input low)
    wr(12'h244, 32'hFFFFFFFE);
    check(32'(irq), 0, "R5 level low one edge later");
    cyc(1);
    check(32'(irq), 1, "R5 level low pends");
    rd(12'h284, 32'h20, "R9 service g2 p0");
    gin[16] = 1; cyc(3);
    wr(12'h264, 32'h1);
    check(32'(irq), 0, "R5 level low released");
    wr(12'h204, 32'h3);
    gin[16] = 0; cyc(3); gin[16] = 1; cyc(3);
    check(32'(irq), 0, "R5 reserved code no pend");
    wr(12'h244, 32'hFFFFFFFF); wr(12'h204, 0);
    // R9 priority: g1p9, g1p12, g4p2
    wr(12'h200, 32'h44000000);
    wr(12'h208, 32'h00000004);
    wr(12'h240, 32'hEDFFFFFF);
    wr(12'h248, 32'hFFFFFFFB);
    gin[50] = 1; cyc(3);
    rd(12'h284, 32'h42, "R9 single g4 p2");
    gin[12] = 1; cyc(3);
    rd(12'h284, 32'h1C, "R9 lower group wins");
    gin[9] = 1; cyc(3);
    rd(12'h284, 32'h19, "R9 lower pin wins");
    wr(12'h260, 32'h02000000);
    rd(12'h284, 32'h1C, "R7 clear then next");
    // R6 mask behaviour
    wr(12'h240, 32'hFFFFFFFF);
    rd(12'h284, 32'h42, "R6 masked line leaves service");
    rd(12'h260, 32'h10000000, "R6 pending kept under mask");
    wr(12'h248, 32'hFFFFFFFF);
    check(32'(irq), 0, "R8 all masked irq low");
    wr(12'h248, 32'hFFFFFFFB);
    check(32'(irq), 1, "R8 unmask restores irq");
    wr(12'h268, 32'h4);
    check(32'(irq), 0, "R8 cleared irq low");
    gin[50] = 0; cyc(3);
    wr(12'h248, 32'hFFFFFFFF);
    gin[50] = 1; cyc(3);
    rd(12'h268, 32'h0, "R6 masked event not recorded");
    cyc(2);
    finish_run();
  end
endmodule